// File: doc/BRIEF.md
# Branch Predecode and Next-Fetch Steering

This block lives in the fetch stage of a small in-order pipeline. Each cycle it looks at the instruction word fetched from the current fetch address and classifies it before decode: plain instruction, unconditional jump, or one of three conditional-branch flavours. It computes the branch destination there, and it picks the address to fetch on the next cycle. Jumps always redirect. A conditional branch follows its encoded hint (likely or unlikely). A branch without a hint is judged by the sign of its offset.

The execute stage reports each conditional branch once its condition is known. The block keeps the direction it guessed for every conditional branch still in flight. When the reported outcome differs from the oldest outstanding guess, it drops all younger guesses, signals a pipeline flush for one cycle and resumes fetch on the correct path. Three saturating counters record how many branches were fetched, and how many conditional branches were guessed right and wrong.

Top module: `fetch_steer`

## Requirements
- R1: While reset is active and on the first cycle after it, the fetch address is 0, the flush output is low and all three counters read 0.
- R2: A fetched word whose bits [31:26] are not one of the branch codes 6'h02, 6'h04, 6'h05 or 6'h06, accepted without stall, advances the fetch address by 4 on the next cycle.
- R3: A word with code 6'h02 (jump) moves the fetch address on the next cycle to its destination. The destination is the fetch address + 4 + (bits [25:0] sign-extended and shifted left by 2).
- R4: A conditional branch with code 6'h04 (likely) moves fetch to its destination. One with code 6'h05 (unlikely) moves fetch to the address + 4.
- R5: A conditional branch with code 6'h06 (no hint) moves fetch to its destination when offset bit 25 is 1 (backward), and to the address + 4 when it is 0 (forward).
- R6: A report from execute whose taken flag differs from the oldest outstanding guess is a misprediction. On the next cycle the fetch address is the reported target if taken, or the reported branch address + 4 if not taken. The flush output is high for exactly that one cycle, and all younger outstanding guesses are discarded. A report that matches the oldest guess retires it without redirect.
- R7: The stall input holds the fetch address, and the word offered during a stall is neither counted nor tracked. A misprediction in a stalled cycle still redirects and flushes.
- R8: The branch counter increments once for each accepted fetch of a word with any of the four branch codes, including words on a path that is later flushed.
- R9: Each report that retires an outstanding guess increments the hit counter when it matches the guess, or the miss counter when it does not.
- R10: Every counter stops at its all-ones value and never wraps.
- R11: A loop-closing branch coded likely mispredicts only on its final, fall-through iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hold fetch for this cycle |
| instr | input | 32 | Word fetched from the current fetch address |
| res_valid | input | 1 | Execute reports a conditional branch outcome |
| res_pc | input | AW (32) | Address of the reported branch |
| res_taken | input | 1 | Actual direction of the reported branch |
| res_target | input | AW (32) | Destination of the reported branch |
| pc_out | output | AW (32) | Current fetch address |
| flush | output | 1 | Squash younger in-flight instructions |
| cnt_branches | output | CW (16) | Branches fetched |
| cnt_hits | output | CW (16) | Correctly guessed conditional branches |
| cnt_misses | output | CW (16) | Mispredicted conditional branches |

## Verification
A misprediction report from execute can arrive in a cycle where fetch is stalled, and the redirect must win over the hold. The bench provokes this by raising stall exactly on the cycle in which the forward unlikely branch, which is actually taken, resolves. Stalls are also scattered every fifth cycle, so they land on correct resolutions and on fresh branch fetches too. A behavioural model predicts the outcome each cycle. The check passes only if the fetch address jumps to the restart address with flush high, and the stalled word is neither counted nor tracked.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam logic [5:0] OP_JUMP      = 6'h02;
    localparam logic [5:0] OP_BR_LIKELY = 6'h04;
    localparam logic [5:0] OP_BR_UNLIK  = 6'h05;
    localparam logic [5:0] OP_BR_NOHINT = 6'h06;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_JUMP = 2'd1,
        BK_COND = 2'd2
    } br_kind_e;
endpackage

// File: rtl/fs_predecode.sv
module fs_predecode
    import fs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic [31:0]   instr,
    output br_kind_e      kind,
    output logic          guess_taken,
    output logic [AW-1:0] dest
);
    localparam int OFF_W = 26;
    localparam int EXT_W = AW - OFF_W - 2;

    logic [5:0]       opc;
    logic [OFF_W-1:0] off;
    logic [AW-1:0]    off_bytes;

    always_comb begin
        opc         = instr[31:26];
        off         = instr[OFF_W-1:0];
        off_bytes   = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
        dest        = pc + AW'(4) + off_bytes;
        kind        = BK_NONE;
        guess_taken = 1'b0;
        case (opc)
            OP_JUMP: begin
                kind        = BK_JUMP;
                guess_taken = 1'b1;
            end
            OP_BR_LIKELY: begin
                kind        = BK_COND;
                guess_taken = 1'b1;
            end
            OP_BR_UNLIK: begin
                kind        = BK_COND;
                guess_taken = 1'b0;
            end
            OP_BR_NOHINT: begin
                kind        = BK_COND;
                guess_taken = off[OFF_W-1];
            end
            default: begin
                kind        = BK_NONE;
                guess_taken = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fs_guess_fifo.sv
module fs_guess_fifo #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    input  logic clear,
    output logic head_bit,
    output logic empty,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic [PW-1:0]    rd;
        logic [PW-1:0]    wr;
        logic [PW:0]      cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  pop_ok, push_ok;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (s_q.cnt == '0);
    assign full     = (s_q.cnt == (PW+1)'(DEPTH));
    assign head_bit = s_q.bits[s_q.rd];

    always_comb begin
        s_d     = s_q;
        pop_ok  = pop && !empty;
        push_ok = push && !full;
        if (clear) begin
            s_d = '0;
        end else begin
            if (pop_ok) begin
                s_d.rd = step_ptr(s_q.rd);
            end
            if (push_ok) begin
                s_d.bits[s_q.wr] = push_bit;
                s_d.wr           = step_ptr(s_q.wr);
            end
            s_d.cnt = s_q.cnt + (PW+1)'(push_ok) - (PW+1)'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fs_sat_ctr.sv
module fs_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (inc && (v_q != '1)) v_d = v_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign value = v_q;
endmodule

// File: rtl/fetch_steer.sv
module fetch_steer
    import fs_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int QD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [31:0]   instr,
    input  logic          res_valid,
    input  logic [AW-1:0] res_pc,
    input  logic          res_taken,
    input  logic [AW-1:0] res_target,
    output logic [AW-1:0] pc_out,
    output logic          flush,
    output logic [CW-1:0] cnt_branches,
    output logic [CW-1:0] cnt_hits,
    output logic [CW-1:0] cnt_misses
);
    localparam int NCTR = 3;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          flush;
    } steer_t;

    steer_t        st_d, st_q;
    br_kind_e      kind;
    logic          guess;
    logic [AW-1:0] dest;
    logic          q_head, q_empty, q_full, q_push;
    logic          retire, miss, accept;
    logic [NCTR-1:0] ctr_inc;
    logic [CW-1:0]   ctr_val [NCTR];

    fs_predecode #(.AW(AW)) u_dec (
        .pc          (st_q.pc),
        .instr       (instr),
        .kind        (kind),
        .guess_taken (guess),
        .dest        (dest)
    );

    always_comb begin
        retire = res_valid && !q_empty;
        miss   = retire && (q_head != res_taken);
        accept = !stall && !miss;
        q_push = accept && (kind == BK_COND);
    end

    fs_guess_fifo #(.DEPTH(QD)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_bit (guess),
        .pop      (retire),
        .clear    (miss),
        .head_bit (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flush = miss;
        if (miss) begin
            st_d.pc = res_taken ? res_target : res_pc + AW'(4);
        end else if (!stall) begin
            if ((kind == BK_JUMP) || ((kind == BK_COND) && guess)) st_d.pc = dest;
            else                                                   st_d.pc = st_q.pc + AW'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctr_inc[0] = accept && (kind != BK_NONE);
        ctr_inc[1] = retire && !miss;
        ctr_inc[2] = miss;
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        fs_sat_ctr #(.W(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ctr_inc[g]),
            .value (ctr_val[g])
        );
    end

    assign pc_out       = st_q.pc;
    assign flush        = st_q.flush;
    assign cnt_branches = ctr_val[0];
    assign cnt_hits     = ctr_val[1];
    assign cnt_misses   = ctr_val[2];
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          miss,
    input logic          res_valid,
    input logic          flush,
    input logic [AW-1:0] pc_out,
    input logic [CW-1:0] cnt_branches,
    input logic [CW-1:0] cnt_misses,
    input logic          q_full,
    input logic          q_push
);
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !flush); // R6
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) flush |-> $past(res_valid)); // R6
    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) q_full |-> !q_push); // R6
    AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n) (stall && !miss) |=> (pc_out == $past(pc_out))); // R7
    AST_BRANCH_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) cnt_branches >= $past(cnt_branches)); // R10
    AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n) (flush && ($past(cnt_misses) != '1)) |-> (cnt_misses == CW'($past(cnt_misses) + 1'b1))); // R9
endmodule

bind fetch_steer fs_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .miss         (miss),
    .res_valid    (res_valid),
    .flush        (flush),
    .pc_out       (pc_out),
    .cnt_branches (cnt_branches),
    .cnt_misses   (cnt_misses),
    .q_full       (q_full),
    .q_push       (q_push)
);

// File: tb/sim_fetch_steer.sv
module sim_fetch_steer;
    localparam int CLK_PERIOD = 10;
    localparam int CMAX       = 65535;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [31:0] instr;
    logic        res_valid;
    logic [31:0] res_pc;
    logic        res_taken;
    logic [31:0] res_target;
    logic [31:0] pc_out;
    logic        flush;
    logic [15:0] cnt_branches, cnt_hits, cnt_misses;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_pc;
    bit          m_flush;
    int          m_cb, m_ch, m_cm;
    logic [31:0] pend_pc[$];
    bit          pend_guess[$];
    int          pend_cyc[$];
    int          cyc = 0;
    int          loop_cnt = 0;
    int          self_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_steer u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .pc_out(pc_out), .flush(flush),
        .cnt_branches(cnt_branches), .cnt_hits(cnt_hits), .cnt_misses(cnt_misses)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input int off);
        logic [31:0] o = off;
        return {op, o[25:0]};
    endfunction

    // Program image: loop at 0x00..0x08, then a set of branch cases.
    function automatic logic [31:0] mem(input logic [31:0] a);
        case (a)
            32'h08:  return enc(6'h04, -3);  // likely loop branch -> 0x00
            32'h0C:  return enc(6'h02, 12);  // jump -> 0x40
            32'h40:  return enc(6'h05, 2);   // unlikely, actually taken -> 0x4C
            32'h4C:  return enc(6'h06, -1);  // no hint backward -> 0x4C
            32'h50:  return enc(6'h06, 2);   // no hint forward, not taken
            32'h54:  return enc(6'h06, 1);   // no hint forward, taken -> 0x5C
            32'h5C:  return enc(6'h02, -1);  // jump to itself
            default: return 32'h0000_0013;
        endcase
    endfunction

    function automatic int opk(input logic [31:0] w);
        case (w[31:26])
            6'h02:                return 1;
            6'h04, 6'h05, 6'h06:  return 2;
            default:              return 0;
        endcase
    endfunction

    function automatic bit hint_of(input logic [31:0] w);
        if (w[31:26] == 6'h04) return 1'b1;
        if (w[31:26] == 6'h05) return 1'b0;
        return w[25];
    endfunction

    function automatic logic [31:0] dest_of(input logic [31:0] a, input logic [31:0] w);
        int off = $signed({{6{w[25]}}, w[25:0]});
        return a + 32'd4 + 32'(off * 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
    endtask

    task automatic step(input bit stl_in);
        logic [31:0] w, rpc, rtgt, nxt;
        bit rv, act, stl, mis, acc;
        string tag;
        w   = mem(m_pc);
        rv  = (pend_pc.size() > 0) && (cyc - pend_cyc[0] >= 2);
        rpc = 0; act = 0; rtgt = 0;
        if (rv) begin
            rpc  = pend_pc[0];
            rtgt = dest_of(rpc, mem(rpc));
            case (rpc)
                32'h08: begin act = (loop_cnt < 999); loop_cnt++; end
                32'h40: act = 1;
                32'h4C: begin act = (self_cnt < 3); self_cnt++; end
                32'h54: act = 1;
                default: act = 0;
            endcase
        end
        stl = stl_in || (rv && rpc == 32'h40);  // stall coincides with a misprediction
        stall = stl; instr = w; res_valid = rv; res_pc = rpc;
        res_taken = act; res_target = rtgt;
        mis = 0;
        if (rv) begin
            mis = (pend_guess[0] != act);
            void'(pend_pc.pop_front()); void'(pend_guess.pop_front()); void'(pend_cyc.pop_front());
            if (mis) begin
                if (m_cm < CMAX) m_cm++;
                pend_pc.delete(); pend_guess.delete(); pend_cyc.delete();
            end else if (m_ch < CMAX) m_ch++;
        end
        acc = !stl && !mis;
        if (acc && opk(w) != 0 && m_cb < CMAX) m_cb++;
        if (acc && opk(w) == 2) begin
            pend_pc.push_back(m_pc); pend_guess.push_back(hint_of(w)); pend_cyc.push_back(cyc);
        end
        if (mis)                                       begin nxt = act ? rtgt : rpc + 32'd4; tag = "R6"; end
        else if (stl)                                  begin nxt = m_pc; tag = "R7"; end
        else if (opk(w) == 1)                          begin nxt = dest_of(m_pc, w); tag = "R3"; end
        else if (opk(w) == 2 && w[31:26] != 6'h06)     begin nxt = hint_of(w) ? dest_of(m_pc, w) : m_pc + 4; tag = "R4"; end
        else if (opk(w) == 2)                          begin nxt = hint_of(w) ? dest_of(m_pc, w) : m_pc + 4; tag = "R5"; end
        else                                           begin nxt = m_pc + 4; tag = "R2"; end
        m_pc = nxt; m_flush = mis;
        @(posedge clk); @(negedge clk); cyc++;
        check(tag, pc_out, m_pc);
        check("R6 flush", {31'b0, flush}, {31'b0, m_flush});
        check("R8 branches", {16'b0, cnt_branches}, m_cb);
        check("R9 hits", {16'b0, cnt_hits}, m_ch);
        check("R9 misses", {16'b0, cnt_misses}, m_cm);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; stall = 0; instr = 0; res_valid = 0;
        res_pc = 0; res_taken = 0; res_target = 0;
        m_pc = 0; m_flush = 0; m_cb = 0; m_ch = 0; m_cm = 0;
        repeat (3) @(negedge clk);
        check("R1 pc", pc_out, 0);
        check("R1 flush", {31'b0, flush}, 0);
        check("R1 counters", {cnt_branches, cnt_hits | cnt_misses}, 0);
        rst_n = 1;
        // loop plus all branch cases, with stalls scattered
        for (int i = 0; i < 20000 && !(loop_cnt >= 1000 && m_pc == 32'h5C && pend_pc.size() == 0); i++)
            step((cyc % 5) == 3);
        check("R11 loop mispredicts once", {16'b0, cnt_misses}, 4);
        check("R9 hits total", {16'b0, cnt_hits}, 1003);
        // self jump fetches a branch every cycle: drive the branch counter to its limit
        for (int i = 0; i < 70000; i++) step(1'b0);
        check("R10 saturation", {16'b0, cnt_branches}, 32'h0000_FFFF);
        check("R10 hold", pc_out, 32'h5C);
        summary();
        $finish;
    end
endmodule